// File: doc/BRIEF.md
# Filter Center-Frequency Auto-Calibration Controller

This block trims the on-chip oscillator of a tunable filter toward a target frequency. A fixed reference clock of 4.433619 MHz sets all of its timing. A vertical sync edge opens a calibration window of about 700 µs. For that whole window the block asks the filter to run as a free oscillator. Inside the window it counts divided oscillator pulses over a fixed number of reference cycles and compares that count with the expected count for the selected target. It then issues up or down steps into a shadow copy of a 6-bit trim code. The number of steps follows the size of the mismatch, and the direction follows its sign.

The trim code seen by the filter changes only on the commit strobe at the end of the window. Once a measurement falls inside the tolerance band of the target, no steps are taken, so the code stops moving and a locked flag is raised. There are two targets. The high one is 4.286 MHz with a ±43 kHz band. The low one is 1.0715 MHz with a ±10.7 kHz band. Both are expressed as expected tick counts and count tolerances over the measurement gate.

Top module: `fcal_ctrl`

## Requirements
- R1: While reset is held and right after it, `trim_code` is 32 (binary 100000), `osc_mode` is 0 and `locked` is 0.
- R2: A rising edge on `vsync` while no window is open opens a window. `osc_mode` is then high for exactly WIN_CYC reference cycles (3104 by default, about 700 µs).
- R3: A `vsync` rising edge while a window is open is ignored. The window is neither restarted nor extended, and no second window follows it.
- R4: The measurement counts `osc_tick` pulses in window cycles SETTLE_CYC to SETTLE_CYC+MEAS_CYC-1 (64 to 1087 by default). Cycle 0 is the first cycle in which `osc_mode` is high.
- R5: `tsel`=1 selects the high target, with an expected count of 990 ±10. `tsel`=0 selects the low target, with an expected count of 247 ±2. If the count is within the band, the code is left unchanged and `locked` becomes 1.
- R6: Outside the band, a count below the expected value raises the code and a count above it lowers the code. The number of steps is the absolute error shifted right (by 1 for `tsel`=1, by 0 for `tsel`=0), clamped to the range 1 to 8.
- R7: `trim_code` changes only on the cycle the window closes. It never changes while `osc_mode` is high, and never by more than 8 per window.
- R8: Stepping saturates at 0 and at 63. It never wraps.
- R9: Any change of `tsel` clears `locked` on the next cycle. If the change happens inside a window, that window leaves the code unchanged and `locked` at 0.
- R10: `locked` is set only by an in-band measurement, and only while a window is open. An out-of-band measurement clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 4.433619 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync | input | 1 | Vertical sync, synchronized inside the block |
| osc_tick | input | 1 | One pulse per divided oscillator period, synchronous to clk |
| tsel | input | 1 | Target select: 1 = 4.286 MHz, 0 = 1.0715 MHz |
| trim_code | output | 6 | Committed trim code for the filter |
| osc_mode | output | 1 | Request to run the filter as a free oscillator (window open) |
| locked | output | 1 | Last measurement was within tolerance |

## Verification
The assertions take `osc_tick` to be a clean pulse of at most one per reference cycle, already in the clock domain. They also take `vsync` to stay high for longer than the synchronizer depth, and `rst_n` to start low. The behavioural oscillator model in the bench uses a phase accumulator whose rate stays below one tick per cycle for every code. It restarts at each window, and it drives pulses only on the falling clock edge. The random stimulus picks the target and the oscillator's natural center code, with gaps of varying length between vsync pulses. Directed windows drive both ends of the code range and inject a second vsync or a target change inside a window.

// File: rtl/fcal_pkg.sv
package fcal_pkg;

   // Target selection encoding shared by the trim unit and the bench
   typedef enum logic {
      TGT_LO = 1'b0,   // 1.0715 MHz band
      TGT_HI = 1'b1    // 4.286 MHz band
   } tgt_e;

   // Timing strobes produced by the window sequencer
   typedef struct packed {
      logic open;     // calibration window active
      logic gate;     // measurement gate active this cycle
      logic last;     // final cycle of the measurement gate
      logic commit;   // final cycle of the window
   } win_s;

endpackage

// File: rtl/fcal_window.sv
module fcal_window
   import fcal_pkg::*;
#(
   parameter int WIN_CYC    = 3104,
   parameter int SETTLE_CYC = 64,
   parameter int MEAS_CYC   = 1024,
   parameter int VS_SYNC    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   output win_s win
);

   localparam int CW       = $clog2(WIN_CYC);
   localparam int GATE_END = SETTLE_CYC + MEAS_CYC;

   logic          vs_s;
   logic          vs_q;
   logic          vs_rise;
   logic          open_q;
   logic [CW-1:0] cnt_q;

   // Optional synchronizer in front of the edge detector
   generate
      if (VS_SYNC == 0) begin : g_nosync
         assign vs_s = vsync;
      end else begin : g_sync
         logic [VS_SYNC-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= (sr_q << 1) | VS_SYNC'(vsync);
         end
         assign vs_s = sr_q[VS_SYNC-1];
      end
   endgenerate

   assign vs_rise = vs_s & ~vs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q   <= 1'b0;
         open_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         vs_q <= vs_s;
         if (!open_q) begin
            if (vs_rise) begin
               open_q <= 1'b1;
               cnt_q  <= '0;
            end
         end else if (cnt_q == CW'(WIN_CYC - 1)) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      win.open   = open_q;
      win.gate   = open_q && (cnt_q >= CW'(SETTLE_CYC)) && (cnt_q < CW'(GATE_END));
      win.last   = open_q && (cnt_q == CW'(GATE_END - 1));
      win.commit = open_q && (cnt_q == CW'(WIN_CYC - 1));
   end

endmodule

// File: rtl/fcal_meas.sv
module fcal_meas #(
   parameter int MEAS_CYC = 1024,
   localparam int MW      = $clog2(MEAS_CYC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate,
   input  logic          last,
   input  logic          osc_tick,
   output logic [MW-1:0] result,
   output logic          done
);

   logic [MW-1:0] acc_q;

   // Counts ticks inside the gate; the final gate cycle is folded into the result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= last;
         if (last) begin
            result <= acc_q + MW'(osc_tick);
            acc_q  <= '0;
         end else if (gate && osc_tick) begin
            acc_q <= acc_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fcal_trim.sv
module fcal_trim
   import fcal_pkg::*;
#(
   parameter int CODE_W    = 6,
   parameter int INIT_CODE = 32,
   parameter int MEAS_CYC  = 1024,
   parameter int EXP_HI    = 990,
   parameter int TOL_HI    = 10,
   parameter int SH_HI     = 1,
   parameter int EXP_LO    = 247,
   parameter int TOL_LO    = 2,
   parameter int SH_LO     = 0,
   parameter int MAX_STEP  = 8,
   parameter bit UP_RAISES = 1'b1,
   localparam int MW       = $clog2(MEAS_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tsel,
   input  win_s              win,
   input  logic              done,
   input  logic [MW-1:0]     result,
   output logic [CODE_W-1:0] code,
   output logic              locked
);

   localparam int SW                = $clog2(MAX_STEP + 1);
   localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

   logic              tsel_q;
   logic              chg;
   logic              stale_q;
   logic [MW-1:0]     exp_c;
   logic [MW-1:0]     tol_c;
   logic [3:0]        sh_c;
   logic [MW-1:0]     mag;
   logic [MW-1:0]     mag_sh;
   logic              slow;
   logic              in_band;
   logic              go_up;
   logic [SW-1:0]     nsteps;
   logic [SW-1:0]     budget_q;
   logic              up_q;
   logic [CODE_W-1:0] shadow_q;

   assign chg = (tsel != tsel_q);

   // Target-dependent constants
   always_comb begin
      if (tgt_e'(tsel_q) == TGT_HI) begin
         exp_c = MW'(EXP_HI);
         tol_c = MW'(TOL_HI);
         sh_c  = 4'(SH_HI);
      end else begin
         exp_c = MW'(EXP_LO);
         tol_c = MW'(TOL_LO);
         sh_c  = 4'(SH_LO);
      end
   end

   // Error magnitude, sign and step count
   always_comb begin
      slow    = (result < exp_c);
      mag     = slow ? (exp_c - result) : (result - exp_c);
      in_band = (mag <= tol_c);
      mag_sh  = mag >> sh_c;
      if (mag_sh == '0)                 nsteps = SW'(1);
      else if (mag_sh > MW'(MAX_STEP))  nsteps = SW'(MAX_STEP);
      else                              nsteps = SW'(mag_sh);
   end

   // Trim polarity: which direction of code raises the oscillator frequency
   generate
      if (UP_RAISES) begin : g_pol_pos
         assign go_up = slow;
      end else begin : g_pol_neg
         assign go_up = ~slow;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tsel_q   <= 1'b0;
         stale_q  <= 1'b0;
         locked   <= 1'b0;
         budget_q <= '0;
         up_q     <= 1'b0;
         shadow_q <= CODE_W'(INIT_CODE);
         code     <= CODE_W'(INIT_CODE);
      end else begin
         tsel_q <= tsel;

         if (!win.open)  stale_q <= 1'b0;
         else if (chg)   stale_q <= 1'b1;

         if (chg) locked <= 1'b0;

         if (done && !stale_q && !chg) begin
            locked   <= in_band;
            budget_q <= in_band ? '0 : nsteps;
            up_q     <= go_up;
         end else if (budget_q != '0) begin
            if (stale_q || chg) begin
               budget_q <= '0;
            end else begin
               budget_q <= budget_q - 1'b1;
               if (up_q) begin
                  if (shadow_q != CMAX) shadow_q <= shadow_q + 1'b1;
               end else begin
                  if (shadow_q != '0)   shadow_q <= shadow_q - 1'b1;
               end
            end
         end

         // Enable strobe: publish the shadow, or roll it back on a stale window
         if (win.commit) begin
            if (!stale_q && !chg) code     <= shadow_q;
            else                  shadow_q <= code;
         end
      end
   end

endmodule

// File: rtl/fcal_ctrl.sv
module fcal_ctrl
   import fcal_pkg::*;
#(
   parameter int CODE_W     = 6,
   parameter int INIT_CODE  = 32,
   parameter int WIN_CYC    = 3104,
   parameter int SETTLE_CYC = 64,
   parameter int MEAS_CYC   = 1024,
   parameter int EXP_HI     = 990,
   parameter int TOL_HI     = 10,
   parameter int SH_HI      = 1,
   parameter int EXP_LO     = 247,
   parameter int TOL_LO     = 2,
   parameter int SH_LO      = 0,
   parameter int MAX_STEP   = 8,
   parameter bit UP_RAISES  = 1'b1,
   parameter int VS_SYNC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync,
   input  logic              osc_tick,
   input  logic              tsel,
   output logic [CODE_W-1:0] trim_code,
   output logic              osc_mode,
   output logic              locked
);

   localparam int MW = $clog2(MEAS_CYC + 1);

   // Elaboration-time parameter checks
   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_codew
         $error("fcal_ctrl: CODE_W out of range");
      end
      if (INIT_CODE < 0 || INIT_CODE >= (1 << CODE_W)) begin : g_bad_init
         $error("fcal_ctrl: INIT_CODE does not fit CODE_W");
      end
      if (MAX_STEP < 1) begin : g_bad_step
         $error("fcal_ctrl: MAX_STEP must be at least 1");
      end
      if (WIN_CYC < SETTLE_CYC + MEAS_CYC + MAX_STEP + 4) begin : g_bad_win
         $error("fcal_ctrl: window too short for gate and stepping");
      end
      if (EXP_HI + TOL_HI > MEAS_CYC || EXP_LO + TOL_LO > MEAS_CYC) begin : g_bad_exp
         $error("fcal_ctrl: expected count exceeds gate length");
      end
      if (SH_HI > 15 || SH_LO > 15) begin : g_bad_sh
         $error("fcal_ctrl: step shift too large");
      end
      if (VS_SYNC < 0 || VS_SYNC > 4) begin : g_bad_sync
         $error("fcal_ctrl: VS_SYNC out of range");
      end
   endgenerate

   win_s          win;
   logic [MW-1:0] meas_res;
   logic          meas_done;

   fcal_window #(
      .WIN_CYC    (WIN_CYC),
      .SETTLE_CYC (SETTLE_CYC),
      .MEAS_CYC   (MEAS_CYC),
      .VS_SYNC    (VS_SYNC)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .vsync (vsync),
      .win   (win)
   );

   fcal_meas #(
      .MEAS_CYC (MEAS_CYC)
   ) u_meas (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate     (win.gate),
      .last     (win.last),
      .osc_tick (osc_tick),
      .result   (meas_res),
      .done     (meas_done)
   );

   fcal_trim #(
      .CODE_W    (CODE_W),
      .INIT_CODE (INIT_CODE),
      .MEAS_CYC  (MEAS_CYC),
      .EXP_HI    (EXP_HI),
      .TOL_HI    (TOL_HI),
      .SH_HI     (SH_HI),
      .EXP_LO    (EXP_LO),
      .TOL_LO    (TOL_LO),
      .SH_LO     (SH_LO),
      .MAX_STEP  (MAX_STEP),
      .UP_RAISES (UP_RAISES)
   ) u_trim (
      .clk    (clk),
      .rst_n  (rst_n),
      .tsel   (tsel),
      .win    (win),
      .done   (meas_done),
      .result (meas_res),
      .code   (trim_code),
      .locked (locked)
   );

   assign osc_mode = win.open;

endmodule

// File: rtl/fcal_ctrl_chk.sv
module fcal_ctrl_chk #(
   parameter int CODE_W   = 6,
   parameter int WIN_CYC  = 3104,
   parameter int MAX_STEP = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tsel,
   input logic [CODE_W-1:0] trim_code,
   input logic              osc_mode,
   input logic              locked
);

   localparam int WW = $clog2(WIN_CYC + 1) + 1;

   logic [WW-1:0] wlen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wlen_q <= '0;
      else if (osc_mode) wlen_q <= wlen_q + 1'b1;
      else               wlen_q <= '0;
   end

   AST_WIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(osc_mode) |-> (wlen_q == WW'(WIN_CYC)));   // R2

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(osc_mode) |-> $stable(trim_code));   // R7

   AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(trim_code) <= int'($past(trim_code)) + MAX_STEP) &&
       (int'($past(trim_code)) <= int'(trim_code) + MAX_STEP)));   // R6

   AST_LOCK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (tsel != $past(tsel)) |=> !locked);   // R9

   AST_LOCK_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> osc_mode);   // R10

endmodule

bind fcal_ctrl fcal_ctrl_chk #(
   .CODE_W   (CODE_W),
   .WIN_CYC  (WIN_CYC),
   .MAX_STEP (MAX_STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tsel      (tsel),
   .trim_code (trim_code),
   .osc_mode  (osc_mode),
   .locked    (locked)
);

// File: tb/fcal_ctrl_test.sv
module fcal_ctrl_test;

   localparam int WIN = 3104;
   localparam int S   = 64;
   localparam int M   = 1024;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vsync = 1'b0;
   logic       osc_tick = 1'b0;
   logic       tsel = 1'b1;
   logic [5:0] trim_code;
   logic       osc_mode;
   logic       locked;

   int total = 0;
   int bad = 0;
   int center = 32;
   int acc = 0;
   int idx = 0;
   int meas_cnt = 0;
   int cycles = 0;

   fcal_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .vsync     (vsync),
      .osc_tick  (osc_tick),
      .tsel      (tsel),
      .trim_code (trim_code),
      .osc_mode  (osc_mode),
      .locked    (locked)
   );

   always #2 clk = ~clk;   // 250 MHz

   // Behavioural oscillator: phase accumulator, rate set by code and center
   function automatic int osc_rate(int code, bit t, int c);
      int r;
      if (t) r = 63360 + (code - c) * 64;
      else   r = 15808 + (code - c) * 16;
      if (r < 0) r = 0;
      if (r > 65535) r = 65535;
      return r;
   endfunction

   always @(negedge clk) begin
      cycles++;
      if (osc_mode) begin
         acc += osc_rate(int'(trim_code), tsel, center);
         if (acc >= 65536) begin
            acc -= 65536;
            osc_tick = 1'b1;
            if (idx >= S && idx < S + M) meas_cnt++;
         end else begin
            osc_tick = 1'b0;
         end
         idx++;
      end else begin
         osc_tick = 1'b0;
         acc = 0;
         idx = 0;
      end
   end

   // Expected next code from the stepping rule
   function automatic int next_code(int code, int cnt, bit t, output bit lk);
      int e, tl, sh, mag, st;
      e  = t ? 990 : 247;
      tl = t ? 10 : 2;
      sh = t ? 1 : 0;
      mag = (cnt > e) ? cnt - e : e - cnt;
      if (mag <= tl) begin
         lk = 1'b1;
         return code;
      end
      lk = 1'b0;
      st = mag >> sh;
      if (st < 1) st = 1;
      if (st > 8) st = 8;
      code = (cnt < e) ? code + st : code - st;
      if (code > 63) code = 63;
      if (code < 0) code = 0;
      return code;
   endfunction

   task automatic check(string req, int act, int exp_v);
      total++;
      if (act != exp_v) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic gap(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_window(bit mid_vs, bit mid_tsel);
      int code0, k, exp_c;
      bit t0, exp_l;
      string tag;
      code0 = int'(trim_code);
      t0 = tsel;
      meas_cnt = 0;
      @(negedge clk);
      vsync = 1'b1;
      while (!osc_mode) @(negedge clk);
      k = 0;
      while (osc_mode) begin
         if (k == 3) vsync = 1'b0;
         if (mid_tsel && k == 500) tsel = ~tsel;
         if (mid_vs && k == 1500) vsync = 1'b1;
         if (mid_vs && k == 1510) vsync = 1'b0;
         if (k == 2000) check("R7 code held mid-window", int'(trim_code), code0);
         k++;
         @(negedge clk);
      end
      check("R2 window length", k, WIN);
      if (mid_tsel) begin
         check("R9 code after target change", int'(trim_code), code0);
         check("R9 lock after target change", int'(locked), 0);
      end else begin
         exp_c = next_code(code0, meas_cnt, t0, exp_l);
         if (exp_l)                      tag = "R5 in-band";
         else if (exp_c == 0 || exp_c == 63) tag = "R8 saturation";
         else                            tag = "R6 step";
         check({tag, " code"}, int'(trim_code), exp_c);
         check("R10 lock", int'(locked), int'(exp_l));
      end
      if (mid_vs) begin
         gap(10);
         check("R3 no retrigger", int'(osc_mode), 0);
      end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      rst_n = 1'b0;
      gap(3);
      check("R1 reset code", int'(trim_code), 32);
      check("R1 reset mode", int'(osc_mode), 0);
      check("R1 reset lock", int'(locked), 0);
      @(negedge clk);
      rst_n = 1'b1;
      gap(5);
      check("R1 code after reset", int'(trim_code), 32);

      // Random scenarios; R4 is covered by the gate-window tick count
      for (int s = 0; s < 4; s++) begin
         tsel = 1'($urandom % 2);
         center = 20 + int'($urandom % 24);
         gap(5);
         for (int w = 0; w < 5; w++) begin
            run_window(1'b0, 1'b0);
            gap(20 + int'($urandom % 180));
         end
         if (locked) begin
            tsel = ~tsel;
            gap(3);
            check("R9 lock clear outside window", int'(locked), 0);
         end
      end

      // Upper saturation
      tsel = 1'b1;
      center = 90;
      gap(5);
      for (int w = 0; w < 6; w++) begin
         run_window(1'b0, 1'b0);
         gap(30);
      end
      check("R8 top saturation", int'(trim_code), 63);

      // Lower saturation
      center = -30;
      for (int w = 0; w < 9; w++) begin
         run_window(1'b0, 1'b0);
         gap(30);
      end
      check("R8 bottom saturation", int'(trim_code), 0);

      // Second vsync inside a window, then target change inside a window
      center = 10;
      run_window(1'b1, 1'b0);
      gap(40);
      run_window(1'b0, 1'b1);
      gap(20);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cycles > 190000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule